// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Interrupt Unit

This block is a memory-mapped timer peripheral. Software programs a reload value, then writes a control word whose low two bits choose an operation (start a single countdown from the reload value, freeze the count, or let it run periodically) and whose next field picks the counting rate. The count rate is derived from the system clock by a prescaler. The base tick period is `BASE_DIV` system clocks, and each higher rate code doubles the period.

Each time the countdown expires, a sticky raw interrupt flag is set. A mask register gates that flag onto a single registered interrupt line. Software clears the flag by writing ones to a write-only acknowledge location. The masked view is recomputed at every expiry, every mask write and every acknowledge write.

The register bus is a simple single-cycle strobe interface. Reads return data one clock after the read strobe.

Top module: `tmr_periph`

## Requirements
- R1: After synchronous reset, every register reads zero, the counter is stopped and `irq_o` is low.
- R2: Writing the control word with op code 0 (bits [1:0]) copies the reload register into the counter and starts a single countdown. After its one expiry the count stays at zero and counting stops.
- R3: Op code 1 freezes the count. Op code 2 resumes counting from the current value and reloads from the reload register at every expiry (periodic). Op code 3 leaves the running state and the count unchanged.
- R4: Control bits [4:2] select the rate. Code k (0 to 3) gives one tick every `BASE_DIV << k` system clocks, counted from the control write. Codes 4 to 7 tick never, so the counter holds.
- R5: Each tick decrements the counter. A tick that finds the count at 1 or 0 is an expiry, so reload N expires on tick N, and reload 0 expires on the first tick.
- R6: An expiry sets raw status bit 0, which then stays set until it is acknowledged.
- R7: Writing the acknowledge address clears every raw bit that is 1 in the written data. The acknowledge address always reads zero.
- R8: Masked status equals raw AND mask. `irq_o` equals masked bit 0 and changes on the same clock edge as the raw or mask change that causes it.
- R9: When an expiry and an acknowledge of bit 0 fall in the same cycle, raw bit 0 ends set.
- R10: Word addresses are: 0 reload, 1 control, 2 count, 3 mask, 4 acknowledge, 5 raw, 6 masked. Read data appears one cycle after `rd_en_i`, and any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Counter expiry and a software acknowledge can hit raw bit 0 in the same clock, which is the case that R9 settles. The bench provokes it by running periodically with reload 1 at the fastest rate, which gives an expiry every second cycle. While the counter runs this way, the bench issues back-to-back acknowledge writes, so some of them land on an expiry cycle. A behavioural model updated at each edge decides the outcome. The bench compares `irq_o` and the read data against that model on every clock, and it also checks that at least one collision really occurred.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_NOP  = 2'd3
  } tmr_op_e;

  localparam int unsigned REG_DIV    = 0;
  localparam int unsigned REG_CTRL   = 1;
  localparam int unsigned REG_COUNT  = 2;
  localparam int unsigned REG_MASK   = 3;
  localparam int unsigned REG_ACK    = 4;
  localparam int unsigned REG_RAW    = 5;
  localparam int unsigned REG_MASKED = 6;
  localparam int unsigned REG_LAST   = 6;

  localparam int unsigned SEL_LSB   = 2;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NUM_RATES = 4;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned BASE_DIV  = 2,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned NUM_RATES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned MAX_LIM = BASE_DIV << (NUM_RATES - 1);
  localparam int unsigned PW      = $clog2(MAX_LIM + 1);
  localparam int unsigned IW      = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1;

  logic [PW-1:0] lim_tab [NUM_RATES];
  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] lim_m1;
  logic          rate_ok;
  logic          active;

  genvar g;
  generate
    for (g = 0; g < NUM_RATES; g++) begin : g_rate
      assign lim_tab[g] = PW'(BASE_DIV << g);
    end
  endgenerate

  assign rate_ok = (32'(sel_i) < NUM_RATES);
  assign lim_m1  = rate_ok ? (lim_tab[sel_i[IW-1:0]] - PW'(1)) : '0;
  assign active  = run_i && rate_ok;
  assign tick_o  = active && !restart_i && (pcnt_q == lim_m1);

  always_ff @(posedge clk) begin
    if (rst || restart_i || !active) begin
      pcnt_q <= '0;
    end else if (pcnt_q == lim_m1) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + PW'(1);
    end
  end

  // R4: prescale phase never passes the limit of the selected rate
  p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (active && !restart_i) |-> (pcnt_q <= lim_m1));
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we_i,
  input  tmr_op_e          op_i,
  input  logic [CNT_W-1:0] div_i,
  input  logic             tick_i,
  output logic             running_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic             running_q;
  logic             periodic_q;

  assign expire_o  = tick_i && (count_q <= CNT_W'(1));
  assign running_o = running_q;
  assign count_o   = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      running_q  <= 1'b0;
      periodic_q <= 1'b0;
    end else if (ctrl_we_i) begin
      case (op_i)
        OP_LOAD: begin
          count_q    <= div_i;
          running_q  <= 1'b1;
          periodic_q <= 1'b0;
        end
        OP_HOLD: running_q <= 1'b0;
        OP_RUN: begin
          running_q  <= 1'b1;
          periodic_q <= 1'b1;
        end
        default: ;
      endcase
    end else if (tick_i) begin
      if (expire_o) begin
        if (periodic_q) begin
          count_q <= div_i;
        end else begin
          count_q   <= '0;
          running_q <= 1'b0;
        end
      end else begin
        count_q <= count_q - CNT_W'(1);
      end
    end
  end

  // R3: a stopped counter keeps its value until the next control write
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!running_q && !ctrl_we_i) |=> $stable(count_q));
  // R2: a single countdown stops at zero after its expiry
  p_oneshot_stop_r2: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !periodic_q) |=> (!running_q && count_q == '0));
  // R3: periodic expiry reloads from the reload register
  p_periodic_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (expire_o && periodic_q) |=> (count_q == $past(div_i)));
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
  parameter int unsigned IRQ_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we_i,
  input  logic             ack_we_i,
  input  logic [IRQ_W-1:0] wbits_i,
  input  logic             expire_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_q, raw_nxt;
  logic [IRQ_W-1:0] mask_q, mask_nxt;
  logic             irq_q;

  always_comb begin
    raw_nxt = raw_q;
    if (ack_we_i) raw_nxt = raw_nxt & ~wbits_i;
    if (expire_i) raw_nxt[0] = 1'b1;
    mask_nxt = mask_we_i ? wbits_i : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_nxt;
      mask_q <= mask_nxt;
      irq_q  <= raw_nxt[0] & mask_nxt[0];
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R6: raw bit 0 stays set unless acknowledged
  p_raw_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (raw_q[0] && !(ack_we_i && wbits_i[0])) |=> raw_q[0]);
  // R7: an acknowledge without expiry clears bit 0
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_we_i && wbits_i[0] && !expire_i) |=> !raw_q[0]);
  // R9: expiry wins over a same-cycle acknowledge
  p_expiry_wins_r9: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> raw_q[0]);
  // R8: interrupt line tracks masked bit 0
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == (raw_q[0] & mask_q[0]));
endmodule

// File: rtl/tmr_periph.sv
module tmr_periph
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned IRQ_W    = 1,
  parameter int unsigned BASE_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  div_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  logic div_we, ctrl_we, mask_we, ack_we;
  logic tick, expire, running;
  logic [CNT_W-1:0] count;
  logic [IRQ_W-1:0] raw, mask;
  tmr_op_e op;

  assign div_we  = wr_en_i && (addr_i == ADDR_W'(REG_DIV));
  assign ctrl_we = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
  assign mask_we = wr_en_i && (addr_i == ADDR_W'(REG_MASK));
  assign ack_we  = wr_en_i && (addr_i == ADDR_W'(REG_ACK));
  assign op      = tmr_op_e'(wdata_i[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (div_we)  div_q  <= wdata_i[CNT_W-1:0];
      if (ctrl_we) ctrl_q <= wdata_i;
    end
  end

  tmr_tick_gen #(
    .BASE_DIV (BASE_DIV),
    .SEL_W    (SEL_W),
    .NUM_RATES(NUM_RATES)
  ) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run_i    (running),
    .restart_i(ctrl_we),
    .sel_i    (ctrl_q[SEL_LSB +: SEL_W]),
    .tick_o   (tick)
  );

  tmr_down_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we_i(ctrl_we),
    .op_i     (op),
    .div_i    (div_q),
    .tick_i   (tick),
    .running_o(running),
    .count_o  (count),
    .expire_o (expire)
  );

  tmr_irq_unit #(
    .IRQ_W(IRQ_W)
  ) u_irq (
    .clk      (clk),
    .rst      (rst),
    .mask_we_i(mask_we),
    .ack_we_i (ack_we),
    .wbits_i  (wdata_i[IRQ_W-1:0]),
    .expire_i (expire),
    .raw_o    (raw),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (32'(addr_i))
      REG_DIV:    rd_mux = DATA_W'(div_q);
      REG_CTRL:   rd_mux = ctrl_q;
      REG_COUNT:  rd_mux = DATA_W'(count);
      REG_MASK:   rd_mux = DATA_W'(mask);
      REG_RAW:    rd_mux = DATA_W'(raw);
      REG_MASKED: rd_mux = DATA_W'(raw & mask);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;

  // R10: reads of unassigned addresses return zero
  p_undef_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (32'(addr_i) > REG_LAST)) |=> (rdata_o == '0));
  // R7: the acknowledge address reads zero
  p_ack_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (addr_i == ADDR_W'(REG_ACK))) |=> (rdata_o == '0));
endmodule

// File: tb/tmr_periph_tb_top.sv
module tmr_periph_tb_top;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 4;
  localparam int unsigned BASE = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_periph #(
    .DATA_W(DW), .ADDR_W(AW), .CNT_W(16), .IRQ_W(1), .BASE_DIV(BASE)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced once per rising edge
  longint m_div, m_ctrl, m_cnt, m_pcnt, m_raw, m_mask, m_irq, m_rdata;
  bit     m_run, m_per;
  int     m_coll;

  function automatic longint m_read(input int a);
    case (a)
      0: return m_div;
      1: return m_ctrl;
      2: return m_cnt;
      3: return m_mask;
      5: return m_raw;
      6: return m_raw & m_mask;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    longint sel, lim, nraw, nmask;
    bit act, ctl_w, tk, ex;
    if (rst) begin
      m_div = 0; m_ctrl = 0; m_cnt = 0; m_pcnt = 0; m_raw = 0;
      m_mask = 0; m_irq = 0; m_rdata = 0; m_run = 0; m_per = 0; m_coll = 0;
    end else begin
      if (rd_en) m_rdata = m_read(int'(addr));
      sel   = (m_ctrl >> 2) & 7;
      lim   = (sel < 4) ? (BASE << sel) : 0;
      act   = m_run && (sel < 4);
      ctl_w = wr_en && (addr == 1);
      tk    = act && !ctl_w && (m_pcnt == lim - 1);
      ex    = tk && (m_cnt <= 1);
      if (ctl_w || !act || m_pcnt == lim - 1) m_pcnt = 0;
      else m_pcnt = m_pcnt + 1;
      nraw = m_raw;
      if (wr_en && addr == 4) nraw = nraw & ~(longint'(wdata) & 1);
      if (ex) nraw = 1;
      if (ex && wr_en && addr == 4 && wdata[0]) m_coll++;
      nmask = (wr_en && addr == 3) ? (longint'(wdata) & 1) : m_mask;
      if (ctl_w) begin
        case (wdata[1:0])
          2'd0: begin m_cnt = m_div; m_run = 1; m_per = 0; end
          2'd1: m_run = 0;
          2'd2: begin m_run = 1; m_per = 1; end
          default: ;
        endcase
      end else if (tk) begin
        if (ex) begin
          if (m_per) m_cnt = m_div;
          else begin m_cnt = 0; m_run = 0; end
        end else m_cnt = m_cnt - 1;
      end
      if (wr_en && addr == 0) m_div = longint'(wdata) & 16'hFFFF;
      if (ctl_w) m_ctrl = longint'(wdata);
      m_raw = nraw; m_mask = nmask; m_irq = nraw & nmask & 1;
    end
  end

  // Cycle-by-cycle comparison against the model (R8 irq, R10 read data)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R8 irq vs model", longint'(irq), m_irq);
      chk("R10 rdata vs model", longint'(rdata), m_rdata);
    end
  end

  task automatic wr(input int a, input longint d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output longint v);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = longint'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cycles_to_irq(output int n);
    n = 0;
    while (!irq && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint v, c1, c2;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R1 / R10: reset state and unassigned addresses
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      chk($sformatf("R1 reset read addr %0d", a), v, 0);
    end
    chk("R1 irq low after reset", longint'(irq), 0);
    rd(2, c1); idle(5); rd(2, c2);
    chk("R1 counter stopped after reset", c2, c1);

    // R2 / R6 / R8: single countdown
    wr(3, 1);
    wr(0, 3);
    wr(1, 0);
    idle(30);
    rd(2, v); chk("R2 count zero after single run", v, 0);
    rd(5, v); chk("R6 raw bit set after expiry", v, 1);
    rd(6, v); chk("R8 masked status", v, 1);
    chk("R8 irq high", longint'(irq), 1);
    idle(20);
    rd(5, v); chk("R6 raw stays set", v, 1);
    rd(2, c1); idle(6); rd(2, c2);
    chk("R2 stopped after one expiry", c2, c1);

    // R7: acknowledge
    wr(4, 1);
    chk("R7 irq low after ack", longint'(irq), 0);
    rd(5, v); chk("R7 raw cleared", v, 0);
    rd(4, v); chk("R7 ack reads zero", v, 0);

    // R3 / R8: periodic, masked off
    wr(3, 0);
    wr(0, 5);
    wr(1, (1 << 2) | 2);
    idle(60);
    wr(1, (1 << 2) | 1);
    rd(2, c1); idle(8); rd(2, c2);
    chk("R3 hold freezes count", c2, c1);
    rd(5, v); chk("R6 raw set by periodic expiry", v, 1);
    chk("R8 irq masked off", longint'(irq), 0);
    wr(3, 1);
    chk("R8 irq rises with mask write", longint'(irq), 1);
    wr(4, 1);

    // R4: reserved rate holds; R3: no-op keeps running
    wr(1, (5 << 2) | 2);
    rd(2, c1); idle(10); rd(2, c2);
    chk("R4 reserved rate holds count", c2, c1);
    wr(1, 3);
    rd(2, c1); rd(2, c2);
    chk("R3 no-op keeps counting", longint'(c1 != c2), 1);

    // R4 / R5: expiry timing
    wr(1, 1);
    wr(4, 1);
    wr(0, 4);
    wr(1, (2 << 2) | 0);
    cycles_to_irq(n);
    chk("R4 R5 reload 4 at rate 2 expires after 32 clocks", n, 32);
    wr(4, 1);
    wr(0, 0);
    wr(1, 0);
    cycles_to_irq(n);
    chk("R5 reload 0 expires on first tick", n, 2);
    wr(4, 1);

    // R9: expiry and acknowledge in the same cycle
    wr(0, 1);
    wr(1, 2);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(4); wdata = 1;
    repeat (9) @(negedge clk);
    wr_en = 1'b0;
    idle(1);
    chk("R9 collision provoked", longint'(m_coll > 0), 1);
    wr(1, 1);
    rd(5, v); chk("R9 raw after collisions", v, m_raw);

    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule